// File: doc/BRIEF.md
# Staged Matrix-Vector Multiply Engine

This engine computes the product c = A·b for a square matrix of 32-bit signed integers. The matrix dimension is set at run time and may go up to a compile-time ceiling. Software-side logic places the dimension and three word base addresses on the inputs and pulses `start`. The engine then runs four strictly separate phases. First it copies the whole matrix from external memory into an on-chip buffer. Next it copies the whole vector into a second buffer. It then forms every output element from the two buffers, one multiply-accumulate per cycle. Last, it writes the finished result vector back to memory.

External memory is reached through two simple ports. The matrix port carries the matrix reads on its read side and the result writes on its write side. The vector port performs reads only. Every transfer is a burst request that carries an address and a word count, and each request uses a valid/ready handshake. The engine takes one read beat per cycle. Write beats use their own valid/ready handshake, and each write burst ends with a one-cycle acknowledge from memory. Only one burst is in flight at a time, and no burst runs past the end of its array.

Top module: `matvec_engine`

## Requirements
- R1: Each result word equals the sum over j of A[i][j]·b[j], computed in 32-bit two's complement with wrap-around on every product and sum and no saturation. The accumulator for each row starts at zero.
- R2: Element (i,j) is read from word address base_a + i·dims + j on the matrix port read side. Element b[j] is read from base_b + j on the vector port. Element c[i] is written to base_c + i on the matrix port write side. Each word is moved exactly once per run.
- R3: All matrix reads finish before the first vector request. All vector reads finish before the first result write request. Requests of different phases are never active in the same cycle.
- R4: Every burst length lies between 1 and 16. The first burst of an array starts at its base address, and each following burst starts where the previous one ended. Each length equals the smaller of 16 and the number of words of that array not yet requested.
- R5: Once a request valid is raised, it stays high with an unchanged address and length until the cycle in which ready is high.
- R6: `done` is high for exactly one cycle, and for a non-empty run that cycle directly follows the cycle in which the final write acknowledge is sampled. `busy` is high from the cycle after an accepted start through the `done` cycle, and it is low during and after reset.
- R7: A start pulse that arrives while `busy` is high has no effect. It does not restart, extend or repeat the run.
- R8: With dims = 0, `done` rises in the cycle after start and no memory request is made.
- R9: The dimension and the three base addresses are captured when start is accepted. Later changes on those inputs do not affect the run in progress.
- R10: The buffers are sized by the parameter MAX_DIM (default 32), and every dims value from 1 to MAX_DIM is computed correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle run request, honoured only when idle |
| dims | input | $clog2(MAX_DIM+1) | Matrix dimension, captured at start |
| base_a | input | AW | Word base address of the matrix |
| base_b | input | AW | Word base address of the vector |
| base_c | input | AW | Word base address of the result |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| mp_rd_req_valid | output | 1 | Matrix port read request valid |
| mp_rd_req_ready | input | 1 | Matrix port read request accepted |
| mp_rd_req_addr | output | AW | Read burst start address |
| mp_rd_req_len | output | $clog2(MAX_BURST+1) | Read burst word count |
| mp_rd_data_valid | input | 1 | Matrix read beat present |
| mp_rd_data | input | 32 | Matrix read beat data |
| mp_wr_req_valid | output | 1 | Matrix port write request valid |
| mp_wr_req_ready | input | 1 | Write request accepted |
| mp_wr_req_addr | output | AW | Write burst start address |
| mp_wr_req_len | output | $clog2(MAX_BURST+1) | Write burst word count |
| mp_wr_data_valid | output | 1 | Write beat present |
| mp_wr_data_ready | input | 1 | Write beat accepted |
| mp_wr_data | output | 32 | Write beat data |
| mp_wr_ack | input | 1 | Write burst completion acknowledge |
| vp_rd_req_valid | output | 1 | Vector port read request valid |
| vp_rd_req_ready | input | 1 | Vector request accepted |
| vp_rd_req_addr | output | AW | Vector burst start address |
| vp_rd_req_len | output | $clog2(MAX_BURST+1) | Vector burst word count |
| vp_rd_data_valid | input | 1 | Vector read beat present |
| vp_rd_data | input | 32 | Vector read beat data |

## Verification
A wrong beat counter or burst generator shows up at the very next request. The address or length on the port then departs from the running issued count, or a request from the following phase appears before all earlier beats have been delivered. A fault in the accumulator or the row and column indices stays hidden through the compute phase. It becomes visible only as wrong words in the result region once the write phase ends. For that reason the memory model checks every request as it is accepted, and the bench compares every result word after `done`. Faults in the handshake or the sequencing show up as a misplaced or repeated `done` pulse, or as a second run triggered by a start that should have been ignored.

// File: rtl/mv_pkg.sv
package mv_pkg;
  localparam int WORD_W = 32;
  typedef logic signed [WORD_W-1:0] word_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_LDA_REQ, ST_LDA_DAT, ST_LDB_REQ, ST_LDB_DAT,
    ST_CALC, ST_STC_REQ, ST_STC_DAT, ST_STC_ACK, ST_DONE
  } phase_e;

  // One multiply-accumulate step, wrapping at the word width.
  function automatic word_t mac_step(word_t acc, word_t a, word_t b);
    word_t prod;
    prod = a * b;
    return acc + prod;
  endfunction
endpackage

// File: rtl/mv_regfile.sv
module mv_regfile #(
  parameter int DEPTH = 32,
  parameter int W     = 32,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/mv_burst_gen.sv
module mv_burst_gen #(
  parameter int AW        = 32,
  parameter int TW        = 11,
  parameter int MAX_BURST = 16,
  parameter int LW        = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic [TW-1:0] total,
  input  logic          fire,
  output logic [AW-1:0] addr,
  output logic [LW-1:0] len,
  output logic          exhausted
);
  localparam logic [TW-1:0] CAP = TW'(MAX_BURST);

  logic [AW-1:0] base_q;
  logic [TW-1:0] total_q, issued, remaining;

  assign remaining = total_q - issued;
  assign len       = (remaining > CAP) ? LW'(MAX_BURST) : LW'(remaining);
  assign addr      = base_q + AW'(issued);
  assign exhausted = (remaining == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      total_q <= '0;
      issued  <= '0;
    end else if (load) begin
      base_q  <= base;
      total_q <= total;
      issued  <= '0;
    end else if (fire) begin
      issued  <= issued + TW'(len);
    end
  end
endmodule

// File: rtl/mv_mac.sv
module mv_mac
  import mv_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  last,
  input  word_t a,
  input  word_t b,
  output word_t sum
);
  word_t acc;

  assign sum = mac_step(acc, a, b);

  always_ff @(posedge clk) begin
    if (!rst_n)  acc <= '0;
    else if (en) acc <= last ? '0 : sum;
  end
endmodule

// File: rtl/matvec_engine.sv
module matvec_engine
  import mv_pkg::*;
#(
  parameter int MAX_DIM   = 32,
  parameter int MAX_BURST = 16,
  parameter int AW        = 32,
  localparam int DW       = $clog2(MAX_DIM + 1),
  localparam int LW       = $clog2(MAX_BURST + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] dims,
  input  logic [AW-1:0] base_a,
  input  logic [AW-1:0] base_b,
  input  logic [AW-1:0] base_c,
  output logic          busy,
  output logic          done,
  output logic          mp_rd_req_valid,
  input  logic          mp_rd_req_ready,
  output logic [AW-1:0] mp_rd_req_addr,
  output logic [LW-1:0] mp_rd_req_len,
  input  logic          mp_rd_data_valid,
  input  logic [31:0]   mp_rd_data,
  output logic          mp_wr_req_valid,
  input  logic          mp_wr_req_ready,
  output logic [AW-1:0] mp_wr_req_addr,
  output logic [LW-1:0] mp_wr_req_len,
  output logic          mp_wr_data_valid,
  input  logic          mp_wr_data_ready,
  output logic [31:0]   mp_wr_data,
  input  logic          mp_wr_ack,
  output logic          vp_rd_req_valid,
  input  logic          vp_rd_req_ready,
  output logic [AW-1:0] vp_rd_req_addr,
  output logic [LW-1:0] vp_rd_req_len,
  input  logic          vp_rd_data_valid,
  input  logic [31:0]   vp_rd_data
);
  localparam int TW  = $clog2(MAX_DIM * MAX_DIM + 1);
  localparam int AIW = $clog2(MAX_DIM * MAX_DIM);
  localparam int BIW = $clog2(MAX_DIM);

  phase_e        st;
  logic [DW-1:0] dims_q, ci, cj;
  logic [AW-1:0] base_b_q, base_c_q;
  logic [TW-1:0] elem, aidx;
  logic [LW-1:0] beat_left;

  // Named internal events.
  logic start_ok, rd_req_fire, wr_req_fire, req_fire;
  logic a_beat, b_beat, wr_beat, beat, burst_end;
  logic mac_en, row_end, calc_end, a_done, b_done;

  logic          gen_load, gen_empty;
  logic [AW-1:0] gen_base, gen_addr;
  logic [TW-1:0] gen_total;
  logic [LW-1:0] gen_len;
  word_t         a_rd, b_rd, c_rd, mac_sum;

  assign start_ok    = start && (st == ST_IDLE);
  assign rd_req_fire = (st == ST_LDA_REQ && mp_rd_req_ready) ||
                       (st == ST_LDB_REQ && vp_rd_req_ready);
  assign wr_req_fire = (st == ST_STC_REQ) && mp_wr_req_ready;
  assign req_fire    = rd_req_fire || wr_req_fire;
  assign a_beat      = (st == ST_LDA_DAT) && mp_rd_data_valid;
  assign b_beat      = (st == ST_LDB_DAT) && vp_rd_data_valid;
  assign wr_beat     = (st == ST_STC_DAT) && mp_wr_data_ready;
  assign beat        = a_beat || b_beat || wr_beat;
  assign burst_end   = beat && (beat_left == LW'(1));
  assign mac_en      = (st == ST_CALC);
  assign row_end     = mac_en && (cj == dims_q - DW'(1));
  assign calc_end    = row_end && (ci == dims_q - DW'(1));
  assign a_done      = (st == ST_LDA_DAT) && burst_end && gen_empty;
  assign b_done      = (st == ST_LDB_DAT) && burst_end && gen_empty;

  always_comb begin
    gen_load  = start_ok;
    gen_base  = base_a;
    gen_total = TW'(dims) * TW'(dims);
    if (a_done) begin
      gen_load  = 1'b1;
      gen_base  = base_b_q;
      gen_total = TW'(dims_q);
    end else if (calc_end) begin
      gen_load  = 1'b1;
      gen_base  = base_c_q;
      gen_total = TW'(dims_q);
    end
  end

  mv_burst_gen #(.AW(AW), .TW(TW), .MAX_BURST(MAX_BURST), .LW(LW)) u_gen (
    .clk(clk), .rst_n(rst_n), .load(gen_load), .base(gen_base), .total(gen_total),
    .fire(req_fire), .addr(gen_addr), .len(gen_len), .exhausted(gen_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
    end else begin
      unique case (st)
        ST_IDLE:    if (start_ok) st <= (dims == '0) ? ST_DONE : ST_LDA_REQ;
        ST_LDA_REQ: if (mp_rd_req_ready) st <= ST_LDA_DAT;
        ST_LDA_DAT: if (burst_end) st <= gen_empty ? ST_LDB_REQ : ST_LDA_REQ;
        ST_LDB_REQ: if (vp_rd_req_ready) st <= ST_LDB_DAT;
        ST_LDB_DAT: if (burst_end) st <= gen_empty ? ST_CALC : ST_LDB_REQ;
        ST_CALC:    if (calc_end) st <= ST_STC_REQ;
        ST_STC_REQ: if (mp_wr_req_ready) st <= ST_STC_DAT;
        ST_STC_DAT: if (burst_end) st <= ST_STC_ACK;
        ST_STC_ACK: if (mp_wr_ack) st <= gen_empty ? ST_DONE : ST_STC_REQ;
        ST_DONE:    st <= ST_IDLE;
        default:    st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dims_q    <= '0;
      base_b_q  <= '0;
      base_c_q  <= '0;
      elem      <= '0;
      beat_left <= '0;
      ci        <= '0;
      cj        <= '0;
      aidx      <= '0;
    end else begin
      if (start_ok) begin
        dims_q   <= dims;
        base_b_q <= base_b;
        base_c_q <= base_c;
      end
      if (gen_load)  elem <= '0;
      else if (beat) elem <= elem + 1'b1;
      if (req_fire)  beat_left <= gen_len;
      else if (beat) beat_left <= beat_left - 1'b1;
      if (start_ok) begin
        ci   <= '0;
        cj   <= '0;
        aidx <= '0;
      end else if (mac_en) begin
        aidx <= aidx + 1'b1;
        if (row_end) begin
          cj <= '0;
          ci <= ci + 1'b1;
        end else begin
          cj <= cj + 1'b1;
        end
      end
    end
  end

  mv_regfile #(.DEPTH(MAX_DIM * MAX_DIM), .W(WORD_W)) u_abuf (
    .clk(clk), .we(a_beat), .waddr(AIW'(elem)), .wdata(mp_rd_data),
    .raddr(AIW'(aidx)), .rdata(a_rd)
  );
  mv_regfile #(.DEPTH(MAX_DIM), .W(WORD_W)) u_bbuf (
    .clk(clk), .we(b_beat), .waddr(BIW'(elem)), .wdata(vp_rd_data),
    .raddr(BIW'(cj)), .rdata(b_rd)
  );
  mv_regfile #(.DEPTH(MAX_DIM), .W(WORD_W)) u_cbuf (
    .clk(clk), .we(row_end), .waddr(BIW'(ci)), .wdata(mac_sum),
    .raddr(BIW'(elem)), .rdata(c_rd)
  );

  mv_mac u_mac (
    .clk(clk), .rst_n(rst_n), .en(mac_en), .last(row_end),
    .a(a_rd), .b(b_rd), .sum(mac_sum)
  );

  assign busy             = (st != ST_IDLE);
  assign done             = (st == ST_DONE);
  assign mp_rd_req_valid  = (st == ST_LDA_REQ);
  assign mp_rd_req_addr   = gen_addr;
  assign mp_rd_req_len    = gen_len;
  assign vp_rd_req_valid  = (st == ST_LDB_REQ);
  assign vp_rd_req_addr   = gen_addr;
  assign vp_rd_req_len    = gen_len;
  assign mp_wr_req_valid  = (st == ST_STC_REQ);
  assign mp_wr_req_addr   = gen_addr;
  assign mp_wr_req_len    = gen_len;
  assign mp_wr_data_valid = (st == ST_STC_DAT);
  assign mp_wr_data       = c_rd;
endmodule

// File: rtl/mv_checks.sv
module mv_checks #(
  parameter int AW        = 32,
  parameter int DW        = 6,
  parameter int LW        = 5,
  parameter int MAX_BURST = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [DW-1:0] dims,
  input logic          busy,
  input logic          done,
  input logic          mp_rd_req_valid,
  input logic          mp_rd_req_ready,
  input logic [AW-1:0] mp_rd_req_addr,
  input logic [LW-1:0] mp_rd_req_len,
  input logic          mp_wr_req_valid,
  input logic          mp_wr_req_ready,
  input logic [AW-1:0] mp_wr_req_addr,
  input logic [LW-1:0] mp_wr_req_len,
  input logic          mp_wr_data_valid,
  input logic          vp_rd_req_valid,
  input logic          vp_rd_req_ready,
  input logic [AW-1:0] vp_rd_req_addr,
  input logic [LW-1:0] vp_rd_req_len
);
  localparam logic [LW-1:0] CAP = LW'(MAX_BURST);

  assert_phase_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mp_rd_req_valid, vp_rd_req_valid, mp_wr_req_valid, mp_wr_data_valid}));

  assert_mp_rd_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mp_rd_req_valid |-> (mp_rd_req_len != '0) && (mp_rd_req_len <= CAP));
  assert_vp_rd_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vp_rd_req_valid |-> (vp_rd_req_len != '0) && (vp_rd_req_len <= CAP));
  assert_mp_wr_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mp_wr_req_valid |-> (mp_wr_req_len != '0) && (mp_wr_req_len <= CAP));

  assert_mp_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mp_rd_req_valid && !mp_rd_req_ready |=>
      mp_rd_req_valid && $stable(mp_rd_req_addr) && $stable(mp_rd_req_len));
  assert_vp_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vp_rd_req_valid && !vp_rd_req_ready |=>
      vp_rd_req_valid && $stable(vp_rd_req_addr) && $stable(vp_rd_req_len));
  assert_mp_wr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mp_wr_req_valid && !mp_wr_req_ready |=>
      mp_wr_req_valid && $stable(mp_wr_req_addr) && $stable(mp_wr_req_len));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  assert_busy_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);

  assert_zero_dims_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && (dims == '0) |=> done);
endmodule

bind matvec_engine mv_checks #(.AW(AW), .DW(DW), .LW(LW), .MAX_BURST(MAX_BURST)) u_checks (
  .clk(clk), .rst_n(rst_n), .start(start), .dims(dims), .busy(busy), .done(done),
  .mp_rd_req_valid(mp_rd_req_valid), .mp_rd_req_ready(mp_rd_req_ready),
  .mp_rd_req_addr(mp_rd_req_addr), .mp_rd_req_len(mp_rd_req_len),
  .mp_wr_req_valid(mp_wr_req_valid), .mp_wr_req_ready(mp_wr_req_ready),
  .mp_wr_req_addr(mp_wr_req_addr), .mp_wr_req_len(mp_wr_req_len),
  .mp_wr_data_valid(mp_wr_data_valid),
  .vp_rd_req_valid(vp_rd_req_valid), .vp_rd_req_ready(vp_rd_req_ready),
  .vp_rd_req_addr(vp_rd_req_addr), .vp_rd_req_len(vp_rd_req_len)
);

// File: tb/sim_matvec_engine.sv
module sim_matvec_engine;
  localparam int MAXD = 32;
  localparam int DW   = $clog2(MAXD + 1);
  localparam int LW   = $clog2(16 + 1);
  localparam int MEMW = 4096;

  logic clk = 1'b0;
  logic rst_n, start;
  logic [DW-1:0] dims;
  logic [31:0] base_a, base_b, base_c;
  logic busy, done;
  logic mp_rd_req_valid, mp_rd_req_ready, mp_rd_data_valid;
  logic [31:0] mp_rd_req_addr, mp_rd_data;
  logic [LW-1:0] mp_rd_req_len;
  logic mp_wr_req_valid, mp_wr_req_ready, mp_wr_data_valid, mp_wr_data_ready, mp_wr_ack;
  logic [31:0] mp_wr_req_addr, mp_wr_data;
  logic [LW-1:0] mp_wr_req_len;
  logic vp_rd_req_valid, vp_rd_req_ready, vp_rd_data_valid;
  logic [31:0] vp_rd_req_addr, vp_rd_data;
  logic [LW-1:0] vp_rd_req_len;

  always #10 clk = ~clk;

  matvec_engine #(.MAX_DIM(MAXD)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .dims(dims),
    .base_a(base_a), .base_b(base_b), .base_c(base_c), .busy(busy), .done(done),
    .mp_rd_req_valid(mp_rd_req_valid), .mp_rd_req_ready(mp_rd_req_ready),
    .mp_rd_req_addr(mp_rd_req_addr), .mp_rd_req_len(mp_rd_req_len),
    .mp_rd_data_valid(mp_rd_data_valid), .mp_rd_data(mp_rd_data),
    .mp_wr_req_valid(mp_wr_req_valid), .mp_wr_req_ready(mp_wr_req_ready),
    .mp_wr_req_addr(mp_wr_req_addr), .mp_wr_req_len(mp_wr_req_len),
    .mp_wr_data_valid(mp_wr_data_valid), .mp_wr_data_ready(mp_wr_data_ready),
    .mp_wr_data(mp_wr_data), .mp_wr_ack(mp_wr_ack),
    .vp_rd_req_valid(vp_rd_req_valid), .vp_rd_req_ready(vp_rd_req_ready),
    .vp_rd_req_addr(vp_rd_req_addr), .vp_rd_req_len(vp_rd_req_len),
    .vp_rd_data_valid(vp_rd_data_valid), .vp_rd_data(vp_rd_data)
  );

  logic [31:0] mem [MEMW];
  logic [31:0] exp_c [MAXD];
  int checks = 0, fails = 0;
  int cyc = 0;
  int cur_n;
  int unsigned cur_ba, cur_bb, cur_bc;
  int unsigned iss [3];
  int rx_a, rx_b, tx_c, reqs, burst_err, order_err, ack_cyc;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] ref_dot(input int i);
    logic [31:0] s = 32'd0;
    for (int j = 0; j < cur_n; j++)
      s = s + mem[(cur_ba + i * cur_n + j) % MEMW] * mem[(cur_bb + j) % MEMW];
    return s;
  endfunction

  // Checks each accepted request against the expected burst shape and phase order.
  task automatic note_burst(input int kind, input int unsigned addr, input int unsigned len);
    int unsigned total, base, want;
    total = (kind == 0) ? cur_n * cur_n : cur_n;
    base  = (kind == 0) ? cur_ba : (kind == 1) ? cur_bb : cur_bc;
    if (kind == 0 && (iss[1] != 0 || iss[2] != 0)) order_err++;
    if (kind == 1 && (rx_a != cur_n * cur_n || iss[2] != 0)) order_err++;
    if (kind == 2 && rx_b != cur_n) order_err++;
    want = (total - iss[kind] > 16) ? 16 : total - iss[kind];
    if (addr != base + iss[kind] || len != want || len == 0) burst_err++;
    iss[kind] += len;
    reqs++;
  endtask

  // Memory model: decisions are made at the falling edge.
  initial begin
    int unsigned ma_addr, va_addr, wr_addr;
    int ma_left, va_left, wr_left, ack_dly;
    ma_left = 0; va_left = 0; wr_left = 0; ack_dly = 0;
    ma_addr = 0; va_addr = 0; wr_addr = 0;
    mp_rd_req_ready = 0; mp_rd_data_valid = 0; mp_rd_data = 0;
    vp_rd_req_ready = 0; vp_rd_data_valid = 0; vp_rd_data = 0;
    mp_wr_req_ready = 0; mp_wr_data_ready = 0; mp_wr_ack = 0;
    forever begin
      @(negedge clk);
      mp_rd_data_valid = 0;
      if (ma_left > 0 && ($urandom % 4) != 0) begin
        mp_rd_data_valid = 1; mp_rd_data = mem[ma_addr % MEMW];
        ma_addr++; ma_left--; rx_a++;
      end
      mp_rd_req_ready = 0;
      if (mp_rd_req_valid && ma_left == 0 && ($urandom % 3) != 0) begin
        mp_rd_req_ready = 1; note_burst(0, mp_rd_req_addr, 32'(mp_rd_req_len));
        ma_addr = mp_rd_req_addr; ma_left = int'(mp_rd_req_len);
      end
      vp_rd_data_valid = 0;
      if (va_left > 0 && ($urandom % 4) != 0) begin
        vp_rd_data_valid = 1; vp_rd_data = mem[va_addr % MEMW];
        va_addr++; va_left--; rx_b++;
      end
      vp_rd_req_ready = 0;
      if (vp_rd_req_valid && va_left == 0 && ($urandom % 3) != 0) begin
        vp_rd_req_ready = 1; note_burst(1, vp_rd_req_addr, 32'(vp_rd_req_len));
        va_addr = vp_rd_req_addr; va_left = int'(vp_rd_req_len);
      end
      mp_wr_ack = 0;
      if (ack_dly > 0) begin
        ack_dly--;
        if (ack_dly == 0) begin mp_wr_ack = 1; ack_cyc = cyc; end
      end
      mp_wr_data_ready = 0;
      if (mp_wr_data_valid && wr_left > 0 && ($urandom % 4) != 0) begin
        mp_wr_data_ready = 1; mem[wr_addr % MEMW] = mp_wr_data;
        wr_addr++; wr_left--; tx_c++;
        if (wr_left == 0) ack_dly = 1 + int'($urandom % 3);
      end
      mp_wr_req_ready = 0;
      if (mp_wr_req_valid && wr_left == 0 && ack_dly == 0 && ($urandom % 3) != 0) begin
        mp_wr_req_ready = 1; note_burst(2, mp_wr_req_addr, 32'(mp_wr_req_len));
        wr_addr = mp_wr_req_addr; wr_left = int'(mp_wr_req_len);
      end
    end
  end

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired: run did not finish");
    summary();
    $finish;
  end

  // mode 0: small signed values, 1: full 32-bit random, 2: extreme values
  task automatic run_case(input int n, input int mode, input bit poke);
    int bad, first_i, wait_cyc, done_cyc;
    cur_n = n;
    cur_ba = $urandom % 64; cur_bb = 1200 + $urandom % 64; cur_bc = 2400 + $urandom % 64;
    for (int k = 0; k < n * n; k++) begin
      if (mode == 0) mem[cur_ba + k] = 32'(int'($urandom % 2001) - 1000);
      else if (mode == 1) mem[cur_ba + k] = $urandom;
      else mem[cur_ba + k] = (k % 2 == 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
    end
    for (int k = 0; k < n; k++) begin
      if (mode == 0) mem[cur_bb + k] = 32'(int'($urandom % 2001) - 1000);
      else if (mode == 1) mem[cur_bb + k] = $urandom;
      else mem[cur_bb + k] = (k % 3 == 0) ? 32'hFFFF_FFFF : 32'h7FFF_FFFF;
    end
    for (int i = 0; i < n; i++) begin
      exp_c[i] = ref_dot(i);
      mem[cur_bc + i] = 32'hDEAD_BEEF;
    end
    iss[0] = 0; iss[1] = 0; iss[2] = 0;
    rx_a = 0; rx_b = 0; tx_c = 0; burst_err = 0; order_err = 0; ack_cyc = -10;
    @(negedge clk);
    dims = DW'(n); base_a = cur_ba; base_b = cur_bb; base_c = cur_bc; start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      // R9: inputs change after capture; R7: start pulses while busy
      dims = DW'(3); base_a = 32'd3000; base_b = 32'd3100; base_c = cur_ba;
      repeat (5) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
    end
    wait_cyc = 0;
    while (!done && wait_cyc < 150000) begin
      @(negedge clk);
      wait_cyc++;
      if (poke && wait_cyc == 40) start = 1;
      if (poke && wait_cyc == 41) start = 0;
    end
    done_cyc = cyc;
    bad = 0; first_i = -1;
    for (int i = 0; i < n; i++)
      if (mem[cur_bc + i] !== exp_c[i]) begin
        bad++;
        if (first_i < 0) first_i = i;
      end
    if (first_i < 0) first_i = 0;
    chk(bad == 0, $sformatf("R1/R2/R10 result n=%0d mode=%0d word %0d", n, mode, first_i),
        mem[cur_bc + first_i], exp_c[first_i]);
    chk(burst_err == 0, $sformatf("R4 burst shape n=%0d", n), burst_err, 0);
    chk(order_err == 0, $sformatf("R3 phase order n=%0d", n), order_err, 0);
    chk(rx_a == n * n && rx_b == n && tx_c == n, $sformatf("R2 beat counts n=%0d", n),
        rx_a + rx_b + tx_c, n * n + 2 * n);
    chk(done_cyc == ack_cyc + 1, $sformatf("R6 done after final ack n=%0d", n), done_cyc, ack_cyc + 1);
    @(negedge clk);
    chk(!done && !busy, $sformatf("R6 done is one pulse n=%0d", n), {done, busy}, 0);
    if (poke) begin
      repeat (10) @(negedge clk);
      chk(!busy && rx_a == n * n, "R7 ignored start left no second run", {busy, 1'b0}, 0);
      chk(mem[cur_ba] !== 32'hDEAD_BEEF && rx_b == n, "R9 captured dims and bases used",
          rx_b, n);
    end
  endtask

  initial begin
    int zr;
    void'($urandom(32'd2024));
    rst_n = 0; start = 0; dims = '0; base_a = 0; base_b = 0; base_c = 0;
    reqs = 0;
    for (int k = 0; k < MEMW; k++) mem[k] = 32'd0;
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R6 idle during reset", {busy, done}, 0);
    chk(!mp_rd_req_valid && !vp_rd_req_valid && !mp_wr_req_valid && !mp_wr_data_valid,
        "R3 no request during reset",
        {mp_rd_req_valid, vp_rd_req_valid, mp_wr_req_valid, mp_wr_data_valid}, 0);
    rst_n = 1;
    @(negedge clk);

    // R8: zero dimension
    zr = reqs;
    dims = '0; start = 1;
    @(negedge clk);
    start = 0;
    chk(done == 1'b1, "R8 done in cycle after start with dims 0", done, 1);
    @(negedge clk);
    chk(!done && !busy && reqs == zr, "R8 no memory request for dims 0", reqs - zr, 0);

    run_case(1, 0, 0);
    run_case(16, 1, 0);
    run_case(17, 1, 0);
    run_case(MAXD, 0, 0);   // R10 maximum dimension
    run_case(17, 2, 0);     // R1 wrap with extreme operands
    run_case(2 + int'($urandom % 29), 1, 0);
    run_case(2 + int'($urandom % 29), 0, 0);
    run_case(5, 1, 1);      // R7 and R9

    summary();
    $finish;
  end
endmodule